// File: doc/BRIEF.md
# Wide-Operand Register Update Unit

This unit executes the register-only instructions of a 32-bit accumulator machine. Every instruction is one 32-bit word. The opcode sits in bits 31:24 and a 24-bit operand fills bits 23:0. For every opcode in the unit, that operand is the whole argument: an add amount, a shift count, or a branch or address offset.

Each cycle the surrounding pipeline may present one instruction with `in_valid`. Along with it come the current A, X, Y, stack pointer, PC, the N/Z/C flags and a condition-true input. One clock later the unit returns the following on registered outputs:
- the next value of every register and of PC;
- the updated flags;
- for a subroutine branch, a push request that carries the return address.

Fetch, memory access and the stack write itself belong to other blocks.

Top module: `regop_exec`

## Requirements
- R1: The outputs are registered. The results of an instruction accepted with `in_valid` high appear one clock later, with `out_valid` high. A cycle without `in_valid` gives `out_valid` and `push_req` low on the next cycle. Reset clears every output to 0.
- R2: Opcodes 0x10, 0x11 and 0x12 add the operand, sign-extended from bit 23, to A, X or Y respectively, modulo 2^32. A negative operand therefore decrements. C passes through unchanged.
- R3: Opcode 0x13 adds the sign-extended operand to the stack pointer and opcode 0x14 subtracts it. N, Z and C pass through unchanged.
- R4: Opcode 0x20 shifts A left and opcode 0x21 shifts A right, logically, by the count in operand bits 5:0.
  - C takes the last bit shifted out.
  - Counts of 32 or more give A = 0. For a count of exactly 32, C is the far-end bit (bit 0 for a left shift, bit 31 for a right shift). For larger counts, C is 0.
  - A count of 0 leaves A and C unchanged.
- R5: Opcode 0x22 rotates the 33-bit value {C,A} left, and opcode 0x23 rotates it right, by the count in operand bits 5:0.
  - Each place moves one bit through C. Rotating left by one gives C = old A[31] and A[0] = old C.
  - A count of 0 leaves A and C unchanged.
- R6: After any opcode that writes A, X or Y (0x10 to 0x12, 0x20 to 0x23, 0x40), N equals bit 31 of the new value. Z is set exactly when all 32 bits of the new value are zero.
- R7: Opcode 0x30 is a conditional branch. When `cond_in` is high, the next PC is PC+1 plus the sign-extended operand. Otherwise the next PC is PC+1.
- R8: Opcode 0x31 branches unconditionally to PC+1 plus the sign-extended operand. It raises `push_req` with `push_addr` = PC+1.
- R9: Opcode 0x40 writes PC+1 plus the sign-extended operand into A. C passes through unchanged.
- R10: Every opcode other than 0x30 and 0x31 gives next PC = PC+1. Registers and flags that the opcode does not name pass through unchanged. Any opcode not listed above changes nothing but PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word: opcode 31:24, operand 23:0 |
| a_in | input | 32 | Current accumulator |
| x_in | input | 32 | Current X index |
| y_in | input | 32 | Current Y index |
| sp_in | input | 32 | Current stack pointer |
| pc_in | input | 32 | Address of this instruction (word units) |
| n_in | input | 1 | Current negative flag |
| z_in | input | 1 | Current zero flag |
| c_in | input | 1 | Current carry flag |
| cond_in | input | 1 | Branch condition is true |
| out_valid | output | 1 | Result registers hold a new result |
| a_out | output | 32 | Next accumulator |
| x_out | output | 32 | Next X index |
| y_out | output | 32 | Next Y index |
| sp_out | output | 32 | Next stack pointer |
| pc_out | output | 32 | Next PC |
| n_out | output | 1 | Next negative flag |
| z_out | output | 1 | Next zero flag |
| c_out | output | 1 | Next carry flag |
| push_req | output | 1 | Return address must be pushed |
| push_addr | output | 32 | Return address to push |

## Verification
All state is one register stage, so a wrong next value shows up at the ports one clock after the instruction that produced it. Because the unit keeps no state across instructions, a fault never lingers or hides until a later instruction.

A bad shift or rotate count decode appears as a wrong A or a wrong C on that same result. The bench therefore drives the count edges 0, 1, 31, 32, 33 and 63, and compares C separately from A.

A displacement adder that drops the sign extension, or that uses PC instead of PC+1, shows up at once in `pc_out` or `push_addr`. It is caught by offsets of +8M-1 and -8M and by a zero offset.

// File: rtl/regop_pkg.sv
package regop_pkg;

    localparam int XLEN = 32;
    localparam int OPW  = 8;
    localparam int IMMW = XLEN - OPW;
    localparam int CNTW = 6;

    typedef enum logic [OPW-1:0] {
        OP_ADDA  = 8'h10,
        OP_ADDX  = 8'h11,
        OP_ADDY  = 8'h12,
        OP_SPADD = 8'h13,
        OP_SPSUB = 8'h14,
        OP_SHL   = 8'h20,
        OP_SHR   = 8'h21,
        OP_ROTL  = 8'h22,
        OP_ROTR  = 8'h23,
        OP_BR    = 8'h30,
        OP_BSR   = 8'h31,
        OP_LEA   = 8'h40
    } opcode_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RIGHT = 2'd1,
        RT_LEFT  = 2'd2,
        RT_RIGHT = 2'd3
    } shkind_e;

    typedef struct packed {
        logic            vld;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] x;
        logic [XLEN-1:0] y;
        logic [XLEN-1:0] sp;
        logic [XLEN-1:0] pc;
        logic            n;
        logic            z;
        logic            c;
        logic            push;
        logic [XLEN-1:0] ret;
    } result_t;

endpackage

// File: rtl/regop_shifter.sv
module regop_shifter #(
    parameter int W  = 32,
    parameter int CW = 6
) (
    input  regop_pkg::shkind_e kind,
    input  logic [W-1:0]       val,
    input  logic               cin,
    input  logic [CW-1:0]      cnt,
    output logic [W-1:0]       res,
    output logic               cout
);
    localparam int VW = W + 1;

    logic [2*W-1:0]  wide_l;
    logic [2*W-1:0]  wide_r;
    logic [2*VW-1:0] dbl;
    logic [2*VW-1:0] rot_l;
    logic [2*VW-1:0] rot_r;
    logic [VW-1:0]   rot_sel;
    int unsigned     k;

    always_comb begin
        wide_l  = {{W{1'b0}}, val} << cnt;
        wide_r  = {val, {W{1'b0}}} >> cnt;
        k       = 32'(cnt) % VW;
        dbl     = {cin, val, cin, val};
        rot_l   = dbl << k;
        rot_r   = dbl >> k;
        rot_sel = (kind == regop_pkg::RT_LEFT) ? rot_l[2*VW-1:VW] : rot_r[VW-1:0];
        res     = val;
        cout    = cin;
        if (cnt != '0) begin
            unique case (kind)
                regop_pkg::SH_LEFT: begin
                    res  = wide_l[W-1:0];
                    cout = wide_l[W];
                end
                regop_pkg::SH_RIGHT: begin
                    res  = wide_r[2*W-1:W];
                    cout = wide_r[W-1];
                end
                default: begin
                    res  = rot_sel[W-1:0];
                    cout = rot_sel[W];
                end
            endcase
        end
    end

endmodule

// File: rtl/regop_target.sv
module regop_target #(
    parameter int W    = 32,
    parameter int IMMW = 24
) (
    input  logic [W-1:0]    pc,
    input  logic [IMMW-1:0] offset,
    output logic [W-1:0]    imm_sx,
    output logic [W-1:0]    seq_pc,
    output logic [W-1:0]    rel_addr
);
    always_comb begin
        imm_sx   = {{(W-IMMW){offset[IMMW-1]}}, offset};
        seq_pc   = pc + W'(1);
        rel_addr = seq_pc + imm_sx;
    end

endmodule

// File: rtl/regop_exec.sv
module regop_exec (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] instr,
    input  logic [31:0] a_in,
    input  logic [31:0] x_in,
    input  logic [31:0] y_in,
    input  logic [31:0] sp_in,
    input  logic [31:0] pc_in,
    input  logic        n_in,
    input  logic        z_in,
    input  logic        c_in,
    input  logic        cond_in,
    output logic        out_valid,
    output logic [31:0] a_out,
    output logic [31:0] x_out,
    output logic [31:0] y_out,
    output logic [31:0] sp_out,
    output logic [31:0] pc_out,
    output logic        n_out,
    output logic        z_out,
    output logic        c_out,
    output logic        push_req,
    output logic [31:0] push_addr
);
    import regop_pkg::*;

    localparam int W = XLEN;

    logic [OPW-1:0]  opc;
    logic [IMMW-1:0] opnd;
    logic [W-1:0]    imm_sx;
    logic [W-1:0]    seq_pc;
    logic [W-1:0]    rel_addr;
    shkind_e         sh_kind;
    logic [W-1:0]    sh_res;
    logic            sh_c;
    result_t         st_d;
    result_t         st_q;

    assign opc  = instr[XLEN-1:IMMW];
    assign opnd = instr[IMMW-1:0];
    assign sh_kind = shkind_e'(opc[1:0]);

    regop_target #(.W(W), .IMMW(IMMW)) u_target (
        .pc       (pc_in),
        .offset   (opnd),
        .imm_sx   (imm_sx),
        .seq_pc   (seq_pc),
        .rel_addr (rel_addr)
    );

    regop_shifter #(.W(W), .CW(CNTW)) u_shift (
        .kind (sh_kind),
        .val  (a_in),
        .cin  (c_in),
        .cnt  (opnd[CNTW-1:0]),
        .res  (sh_res),
        .cout (sh_c)
    );

    always_comb begin
        logic          wr_flags;
        logic [W-1:0]  flag_src;
        st_d      = st_q;
        st_d.vld  = in_valid;
        st_d.push = 1'b0;
        wr_flags  = 1'b0;
        flag_src  = '0;
        if (in_valid) begin
            st_d.a   = a_in;
            st_d.x   = x_in;
            st_d.y   = y_in;
            st_d.sp  = sp_in;
            st_d.pc  = seq_pc;
            st_d.n   = n_in;
            st_d.z   = z_in;
            st_d.c   = c_in;
            st_d.ret = st_q.ret;
            case (opc)
                OP_ADDA: begin
                    st_d.a   = a_in + imm_sx;
                    flag_src = st_d.a;
                    wr_flags = 1'b1;
                end
                OP_ADDX: begin
                    st_d.x   = x_in + imm_sx;
                    flag_src = st_d.x;
                    wr_flags = 1'b1;
                end
                OP_ADDY: begin
                    st_d.y   = y_in + imm_sx;
                    flag_src = st_d.y;
                    wr_flags = 1'b1;
                end
                OP_SPADD: st_d.sp = sp_in + imm_sx;
                OP_SPSUB: st_d.sp = sp_in - imm_sx;
                OP_SHL, OP_SHR, OP_ROTL, OP_ROTR: begin
                    st_d.a   = sh_res;
                    st_d.c   = sh_c;
                    flag_src = sh_res;
                    wr_flags = 1'b1;
                end
                OP_BR: begin
                    if (cond_in) st_d.pc = rel_addr;
                end
                OP_BSR: begin
                    st_d.pc   = rel_addr;
                    st_d.push = 1'b1;
                    st_d.ret  = seq_pc;
                end
                OP_LEA: begin
                    st_d.a   = rel_addr;
                    flag_src = rel_addr;
                    wr_flags = 1'b1;
                end
                default: ;
            endcase
            if (wr_flags) begin
                st_d.n = flag_src[W-1];
                st_d.z = (flag_src == '0);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign a_out     = st_q.a;
    assign x_out     = st_q.x;
    assign y_out     = st_q.y;
    assign sp_out    = st_q.sp;
    assign pc_out    = st_q.pc;
    assign n_out     = st_q.n;
    assign z_out     = st_q.z;
    assign c_out     = st_q.c;
    assign push_req  = st_q.push;
    assign push_addr = st_q.ret;

endmodule

// File: rtl/regop_chk.sv
module regop_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] instr,
    input logic [31:0] x_in,
    input logic [31:0] pc_in,
    input logic        c_in,
    input logic        cond_in,
    input logic        out_valid,
    input logic [31:0] a_out,
    input logic [31:0] x_out,
    input logic [31:0] pc_out,
    input logic        n_out,
    input logic        z_out,
    input logic        c_out,
    input logic        push_req,
    input logic [31:0] push_addr
);
    logic [31:0] imm_ext;
    logic [7:0]  opc;
    assign imm_ext = {{8{instr[23]}}, instr[23:0]};
    assign opc     = instr[31:24];

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !push_req));

    // R2
    x_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opc == 8'h11) |=>
            (x_out == $past(x_in) + $past(imm_ext) && c_out == $past(c_in)));

    // R6
    a_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opc == 8'h10) |=> (z_out == (a_out == 32'd0) && n_out == a_out[31]));

    // R7
    br_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opc == 8'h30 && !cond_in) |=> pc_out == $past(pc_in) + 32'd1);

    // R8
    bsr_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opc == 8'h31) |=> (push_req && push_addr == $past(pc_in) + 32'd1));

    // R10
    seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opc != 8'h30 && opc != 8'h31) |=> (pc_out == $past(pc_in) + 32'd1 && !push_req));

endmodule

bind regop_exec regop_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .instr     (instr),
    .x_in      (x_in),
    .pc_in     (pc_in),
    .c_in      (c_in),
    .cond_in   (cond_in),
    .out_valid (out_valid),
    .a_out     (a_out),
    .x_out     (x_out),
    .pc_out    (pc_out),
    .n_out     (n_out),
    .z_out     (z_out),
    .c_out     (c_out),
    .push_req  (push_req),
    .push_addr (push_addr)
);

// File: tb/tb_regop_exec.sv
module tb_regop_exec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] a_in = '0, x_in = '0, y_in = '0, sp_in = '0, pc_in = '0;
    logic        n_in = 1'b0, z_in = 1'b0, c_in = 1'b0, cond_in = 1'b0;
    logic        out_valid;
    logic [31:0] a_out, x_out, y_out, sp_out, pc_out, push_addr;
    logic        n_out, z_out, c_out, push_req;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    regop_exec dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .a_in(a_in), .x_in(x_in), .y_in(y_in), .sp_in(sp_in), .pc_in(pc_in),
        .n_in(n_in), .z_in(z_in), .c_in(c_in), .cond_in(cond_in),
        .out_valid(out_valid), .a_out(a_out), .x_out(x_out), .y_out(y_out),
        .sp_out(sp_out), .pc_out(pc_out), .n_out(n_out), .z_out(z_out),
        .c_out(c_out), .push_req(push_req), .push_addr(push_addr)
    );

    typedef struct {
        logic [31:0] a, x, y, sp, pc, ret;
        logic        n, z, c, push;
        string       ta, tx, ty, ts, tp, tf, tc, tq;
    } exp_t;

    exp_t sb[$];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [7:0] op, input logic [23:0] opnd,
            input logic [31:0] a, input logic [31:0] x, input logic [31:0] y,
            input logic [31:0] sp, input logic [31:0] pc,
            input logic n, input logic z, input logic c, input logic cond);
        exp_t e;
        logic [31:0] sx;
        logic [31:0] nxt;
        logic        t;
        int          cnt;
        bit          flags;
        sx  = {{8{opnd[23]}}, opnd};
        nxt = pc + 32'd1;
        cnt = int'(opnd[5:0]);
        e.a = a; e.x = x; e.y = y; e.sp = sp; e.pc = nxt;
        e.n = n; e.z = z; e.c = c; e.push = 1'b0; e.ret = 32'hx;
        e.ta = "R10"; e.tx = "R10"; e.ty = "R10"; e.ts = "R10";
        e.tp = "R10"; e.tf = "R10"; e.tc = "R10"; e.tq = "R10";
        flags = 1'b0;
        case (op)
            8'h10: begin e.a = a + sx; e.ta = "R2"; e.tc = "R2"; flags = 1'b1; end
            8'h11: begin e.x = x + sx; e.tx = "R2"; e.tc = "R2"; flags = 1'b1; end
            8'h12: begin e.y = y + sx; e.ty = "R2"; e.tc = "R2"; flags = 1'b1; end
            8'h13: begin e.sp = sp + sx; e.ts = "R3"; e.tf = "R3"; e.tc = "R3"; end
            8'h14: begin e.sp = sp - sx; e.ts = "R3"; e.tf = "R3"; e.tc = "R3"; end
            8'h20: begin
                for (int i = 0; i < cnt; i++) begin e.c = e.a[31]; e.a = e.a << 1; end
                e.ta = "R4"; e.tc = "R4"; flags = 1'b1;
            end
            8'h21: begin
                for (int i = 0; i < cnt; i++) begin e.c = e.a[0]; e.a = e.a >> 1; end
                e.ta = "R4"; e.tc = "R4"; flags = 1'b1;
            end
            8'h22: begin
                for (int i = 0; i < cnt; i++) begin
                    t = e.a[31]; e.a = {e.a[30:0], e.c}; e.c = t;
                end
                e.ta = "R5"; e.tc = "R5"; flags = 1'b1;
            end
            8'h23: begin
                for (int i = 0; i < cnt; i++) begin
                    t = e.a[0]; e.a = {e.c, e.a[31:1]}; e.c = t;
                end
                e.ta = "R5"; e.tc = "R5"; flags = 1'b1;
            end
            8'h30: begin if (cond) e.pc = nxt + sx; e.tp = "R7"; end
            8'h31: begin
                e.pc = nxt + sx; e.push = 1'b1; e.ret = nxt;
                e.tp = "R8"; e.tq = "R8";
            end
            8'h40: begin e.a = nxt + sx; e.ta = "R9"; e.tc = "R9"; flags = 1'b1; end
            default: ;
        endcase
        if (flags) begin
            e.n = (op == 8'h11) ? e.x[31] : (op == 8'h12) ? e.y[31] : e.a[31];
            e.z = (op == 8'h11) ? (e.x == 0) : (op == 8'h12) ? (e.y == 0) : (e.a == 0);
            e.tf = "R6";
        end
        return e;
    endfunction

    task automatic issue(input logic [7:0] op, input logic [23:0] opnd,
                         input logic [31:0] a, input logic cin, input logic cond);
        @(negedge clk);
        in_valid = 1'b1;
        instr    = {op, opnd};
        a_in     = a;
        x_in     = $urandom;
        y_in     = $urandom;
        sp_in    = $urandom;
        pc_in    = $urandom;
        n_in     = 1'($urandom);
        z_in     = 1'($urandom);
        c_in     = cin;
        cond_in  = cond;
        sb.push_back(model(op, opnd, a, x_in, y_in, sp_in, pc_in, n_in, z_in, c_in, cond));
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R1", "unexpected out_valid", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(a_out == e.a, e.ta, "a_out", a_out, e.a);
                check(x_out == e.x, e.tx, "x_out", x_out, e.x);
                check(y_out == e.y, e.ty, "y_out", y_out, e.y);
                check(sp_out == e.sp, e.ts, "sp_out", sp_out, e.sp);
                check(pc_out == e.pc, e.tp, "pc_out", pc_out, e.pc);
                check(n_out == e.n, e.tf, "n_out", 32'(n_out), 32'(e.n));
                check(z_out == e.z, e.tf, "z_out", 32'(z_out), 32'(e.z));
                check(c_out == e.c, e.tc, "c_out", 32'(c_out), 32'(e.c));
                check(push_req == e.push, e.tq, "push_req", 32'(push_req), 32'(e.push));
                if (e.push)
                    check(push_addr == e.ret, "R8", "push_addr", push_addr, e.ret);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        logic [7:0] ops [12];
        ops = '{8'h10, 8'h11, 8'h12, 8'h13, 8'h14, 8'h20, 8'h21, 8'h22, 8'h23,
                8'h30, 8'h31, 8'h40};

        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0 && push_req == 1'b0, "R1", "reset valid/push",
              {30'd0, out_valid, push_req}, 32'd0);
        check(a_out == 0 && pc_out == 0 && push_addr == 0, "R1", "reset regs",
              a_out | pc_out | push_addr, 32'd0);
        rst_n = 1'b1;

        // R2: increment, decrement, wrap to zero, extreme operands
        issue(8'h10, 24'd5, 32'd10, 1'b1, 1'b0);
        issue(8'h10, 24'hFFFFFF, 32'd1, 1'b0, 1'b0);
        issue(8'h11, 24'h7FFFFF, 32'h0000_0001, 1'b1, 1'b0);
        issue(8'h12, 24'h800000, 32'h0, 1'b0, 1'b0);
        issue(8'h10, 24'hFFFFFF, 32'h0, 1'b1, 1'b0);
        // R3: stack pointer adjust
        issue(8'h13, 24'h000010, 32'h0, 1'b0, 1'b0);
        issue(8'h14, 24'hFFFFFC, 32'h0, 1'b1, 1'b0);
        // R4: logical shift count edges
        foreach (ops[i]) begin end
        for (int k = 0; k < 2; k++) begin
            issue(8'h20 + 8'(k), 24'd0, 32'h8000_0001, 1'b1, 1'b0);
            issue(8'h20 + 8'(k), 24'd1, 32'h8000_0001, 1'b0, 1'b0);
            issue(8'h20 + 8'(k), 24'd31, 32'hC000_0003, 1'b0, 1'b0);
            issue(8'h20 + 8'(k), 24'd32, 32'h8000_0001, 1'b0, 1'b0);
            issue(8'h20 + 8'(k), 24'd33, 32'hFFFF_FFFF, 1'b1, 1'b0);
            issue(8'h20 + 8'(k), 24'hABC03F, 32'hFFFF_FFFF, 1'b1, 1'b0);
        end
        // R5: rotate through carry count edges
        for (int k = 0; k < 2; k++) begin
            issue(8'h22 + 8'(k), 24'd0, 32'h1234_5678, 1'b1, 1'b0);
            issue(8'h22 + 8'(k), 24'd1, 32'h8000_0001, 1'b0, 1'b0);
            issue(8'h22 + 8'(k), 24'd32, 32'h8000_0001, 1'b1, 1'b0);
            issue(8'h22 + 8'(k), 24'd33, 32'hDEAD_BEEF, 1'b1, 1'b0);
            issue(8'h22 + 8'(k), 24'd63, 32'hDEAD_BEEF, 1'b0, 1'b0);
        end
        // R7: branch taken / not taken, extreme displacements
        issue(8'h30, 24'h7FFFFF, 32'h0, 1'b0, 1'b1);
        issue(8'h30, 24'h800000, 32'h0, 1'b0, 1'b1);
        issue(8'h30, 24'h800000, 32'h0, 1'b0, 1'b0);
        // R8: subroutine branch with push
        issue(8'h31, 24'h000000, 32'h0, 1'b0, 1'b0);
        issue(8'h31, 24'h800000, 32'h0, 1'b1, 1'b0);
        // R9: effective address
        issue(8'h40, 24'h7FFFFF, 32'h0, 1'b1, 1'b0);
        issue(8'h40, 24'hFFFFFF, 32'h0, 1'b0, 1'b0);
        // R10: unknown opcodes change only PC
        issue(8'hFF, 24'h123456, 32'hCAFE_0000, 1'b1, 1'b1);
        issue(8'h00, 24'h800000, 32'h0, 1'b0, 1'b1);

        // R1: gap cycle yields no valid output
        idle();
        @(negedge clk);
        check(out_valid == 1'b0 && push_req == 1'b0, "R1", "idle cycle valid/push",
              {30'd0, out_valid, push_req}, 32'd0);

        // random mix over all opcodes
        for (int i = 0; i < 400; i++) begin
            issue(ops[$urandom_range(0, 11)], 24'($urandom), $urandom,
                  1'($urandom), 1'($urandom));
        end
        idle();
        @(negedge clk);
        @(negedge clk);
        check(sb.size() == 0, "R1", "scoreboard drained", 32'(sb.size()), 32'd0);
        finish_run();
    end

endmodule